// File: doc/BRIEF.md
# Priority Interrupt Controller Register Front End

This block is the byte-wide, two-address software interface of an eight-line priority interrupt controller. Software writes a short sequence of setup words to address 0 and then address 1 to choose the vector base, single or cascaded operation and the end-of-interrupt policy. After setup, address 1 writes load the line mask and address 0 writes carry operation commands. Those commands retire in-service lines, move the rotating priority base, pick which vector a status read returns, arm a poll and switch special mask mode.

The request latch and the priority resolver sit outside the block. The block receives the latched request vector, plus the resolver's verdict as a valid flag and a winning line. It drives the mask, the in-service vector, the rotation base and the nesting flags back to the resolver. An acknowledge from the processor, or a poll read, takes the winning line. The block reports each take on a strobe so that the request latch can clear an edge-held request.

Top module: `irq_ctl_regif`

## Requirements
- R1: After reset, all held state is zero (mask, in-service, rotation base, vector base and every flag) and the setup sequencer is idle, so the next address 1 write loads the mask.
- R2: An address 0 write with bit 4 set starts setup. It clears the mask, the in-service vector, the rotation base, the vector base and all mode flags, overriding anything else in that cycle. It records bit 0 as the "fourth word follows" flag and bit 1 as the single-controller flag, and waits for the second word.
- R3: In the second-word state, an address 1 write stores wdata AND F8h as the vector base. The sequencer then goes to the fourth-word state if single and fourth-word are both set, to idle if single is set alone, and to the third-word state otherwise.
- R4: In the third-word state, an address 1 write changes no register. The sequencer moves to the fourth-word state if the fourth-word flag is set, and to idle otherwise.
- R5: In the fourth-word state, an address 1 write sets special-fully-nested from bit 4 and auto-EOI from bit 1, and returns the sequencer to idle.
- R6: In the idle state, an address 1 write loads the mask with wdata.
- R7: An address 0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. If bit 1 is set, read-select loads from bit 0. If bit 6 is set, special mask loads from bit 5. Any field whose enable bit is clear keeps its value.
- R8: Commands are wdata[7:5] on an address 0 write with bits 4 and 3 clear. Command 0 clears rotate-on-auto-EOI and command 4 sets it.
- R9: Command 1 clears the in-service bit of highest priority. Priority runs from line base, then base+1, and so on, modulo 8. Command 5 does the same and also sets the base to the cleared line plus 1. With no in-service bit set, both do nothing.
- R10: Command 3 clears in-service bit wdata[2:0]. Command 6 sets the base to wdata[2:0]+1. Command 7 does both. Command 2 has no effect.
- R11: A take (ack with win_valid, or a poll read with win_valid) of line L sets in-service bit L when auto-EOI is off. When auto-EOI is on, it leaves in-service unchanged and, if rotate-on-auto-EOI is set, moves the base to L+1 modulo 8. take_o and take_line_o report it in the same cycle.
- R12: A read while poll is armed returns 80h OR the winning line and takes that line, or returns 00h with no winner. In both cases the poll is disarmed.
- R13: A read that is not a poll returns the in-service vector from address 0 if read-select is 1, the request vector from address 0 if read-select is 0, and the mask from address 1. rdata is 00h when no read is requested.
- R14: In one cycle, a command's in-service clears are computed from the pre-cycle vector and a take's set is applied on top. A base written by a command overrides a rotation from the same cycle's take. A mode command arming poll overrides the disarm of a same-cycle poll read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of rd_en |
| req_vec | input | 8 | Latched request vector from the request latch |
| win_valid | input | 1 | Priority resolver has a winner |
| win_line | input | 3 | Winning line from the resolver |
| ack | input | 1 | Processor acknowledge of the current winner |
| take_o | output | 1 | A line is taken this cycle |
| take_line_o | output | 3 | Line taken this cycle |
| mask_o | output | 8 | Line mask |
| isr_o | output | 8 | In-service vector |
| base_o | output | 3 | Rotating priority base (line of highest priority) |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| spec_mask_o | output | 1 | Special mask mode |
| sfnm_o | output | 1 | Special fully nested mode |

## Verification
Two pairs of functions can fall in one cycle. A processor acknowledge can land in the same cycle as an end-of-interrupt command, and a poll read can land in the same cycle as a mode write that re-arms poll. The bench provokes both on purpose: it acknowledges a new line while issuing a non-specific end-of-interrupt, and it reads and re-arms poll in one cycle. It judges both against the ordering in R14. A long random phase then mixes writes, reads and takes freely, with the behavioural model checking every clock.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    // Number of request lines; must be a power of two matching the byte bus.
    localparam int unsigned LINES = 8;
    localparam int unsigned LW    = $clog2(LINES);
    localparam int unsigned DW    = 8;

    // Bit positions decoded from address 0 writes.
    localparam int unsigned INIT_BIT  = 4;
    localparam int unsigned MODE_BIT  = 3;
    localparam int unsigned POLL_BIT  = 2;
    localparam int unsigned RSEL_EN   = 1;
    localparam int unsigned RSEL_VAL  = 0;
    localparam int unsigned SMSK_EN   = 6;
    localparam int unsigned SMSK_VAL  = 5;
    localparam int unsigned W1_FOURTH = 0;
    localparam int unsigned W1_SINGLE = 1;
    localparam int unsigned W4_SFNM   = 4;
    localparam int unsigned W4_AEOI   = 1;
    localparam int unsigned OP_LSB    = 5;

    localparam logic [DW-1:0] VBASE_KEEP = ~DW'(LINES - 1);
    localparam logic [DW-1:0] POLL_FLAG  = DW'(8'h80);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_W2   = 2'd1,
        SEQ_W3   = 2'd2,
        SEQ_W4   = 2'd3
    } seq_e;

    typedef enum logic [2:0] {
        OP_RAE_CLR = 3'd0,
        OP_EOI     = 3'd1,
        OP_NOP     = 3'd2,
        OP_SEOI    = 3'd3,
        OP_RAE_SET = 3'd4,
        OP_REOI    = 3'd5,
        OP_SETPRI  = 3'd6,
        OP_RSEOI   = 3'd7
    } op_e;

    typedef struct packed {
        seq_e             seq;
        logic [LINES-1:0] mask;
        logic [LINES-1:0] isr;
        logic [LW-1:0]    base;
        logic [DW-1:0]    vbase;
        logic             aeoi;
        logic             rae;
        logic             smask;
        logic             sfnm;
        logic             poll;
        logic             rsel;
        logic             want4;
        logic             single;
    } regs_t;

endpackage

// File: rtl/irq_ctl_rotfind.sv
// Finds the first set bit of vec, scanning from position base upward with wrap.
module irq_ctl_rotfind #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] base,
    output logic          hit,
    output logic [LW-1:0] line
);

    always_comb begin
        hit  = 1'b0;
        line = '0;
        // Scan from the far end so the nearest position to base wins last.
        for (int k = N - 1; k >= 0; k--) begin
            logic [LW-1:0] idx;
            idx = base + LW'(k);
            if (vec[idx]) begin
                hit  = 1'b1;
                line = idx;
            end
        end
    end

endmodule

// File: rtl/irq_ctl_initseq.sv
// Setup word sequencer: next state and load strobes for address 1 writes.
module irq_ctl_initseq
    import irq_ctl_pkg::*;
(
    input  irq_ctl_pkg::seq_e seq_q,
    input  logic              wr1,
    input  logic              single_q,
    input  logic              want4_q,
    output irq_ctl_pkg::seq_e seq_nx,
    output logic              ld_mask,
    output logic              ld_vbase,
    output logic              ld_w4
);

    always_comb begin
        seq_nx   = seq_q;
        ld_mask  = 1'b0;
        ld_vbase = 1'b0;
        ld_w4    = 1'b0;
        if (wr1) begin
            unique case (seq_q)
                SEQ_IDLE: ld_mask = 1'b1;
                SEQ_W2: begin
                    ld_vbase = 1'b1;
                    if (single_q) seq_nx = want4_q ? SEQ_W4 : SEQ_IDLE;
                    else          seq_nx = SEQ_W3;
                end
                SEQ_W3: seq_nx = want4_q ? SEQ_W4 : SEQ_IDLE;
                SEQ_W4: begin
                    ld_w4  = 1'b1;
                    seq_nx = SEQ_IDLE;
                end
                default: seq_nx = SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_ctl_cmddec.sv
// Decodes address 0 mode and operation commands into update requests.
module irq_ctl_cmddec
    import irq_ctl_pkg::*;
(
    input  logic             cmd_wr,
    input  logic [DW-1:0]    wdata,
    input  logic [LINES-1:0] isr,
    input  logic [LW-1:0]    base,
    output logic [LINES-1:0] isr_clr,
    output logic             base_we,
    output logic [LW-1:0]    base_nv,
    output logic             rae_we,
    output logic             rae_nv,
    output logic             poll_set,
    output logic             rsel_we,
    output logic             rsel_nv,
    output logic             smask_we,
    output logic             smask_nv
);

    logic          eoi_hit;
    logic [LW-1:0] eoi_line;
    logic [LW-1:0] fld;
    op_e           op;

    irq_ctl_rotfind #(.N(LINES), .LW(LW)) u_eoi_find (
        .vec  (isr),
        .base (base),
        .hit  (eoi_hit),
        .line (eoi_line)
    );

    assign fld = wdata[LW-1:0];
    assign op  = op_e'(wdata[OP_LSB +: 3]);

    always_comb begin
        isr_clr  = '0;
        base_we  = 1'b0;
        base_nv  = '0;
        rae_we   = 1'b0;
        rae_nv   = 1'b0;
        poll_set = 1'b0;
        rsel_we  = 1'b0;
        rsel_nv  = 1'b0;
        smask_we = 1'b0;
        smask_nv = 1'b0;
        if (cmd_wr && !wdata[INIT_BIT]) begin
            if (wdata[MODE_BIT]) begin
                poll_set = wdata[POLL_BIT];
                rsel_we  = wdata[RSEL_EN];
                rsel_nv  = wdata[RSEL_VAL];
                smask_we = wdata[SMSK_EN];
                smask_nv = wdata[SMSK_VAL];
            end else begin
                unique case (op)
                    OP_RAE_CLR, OP_RAE_SET: begin
                        rae_we = 1'b1;
                        rae_nv = (op == OP_RAE_SET);
                    end
                    OP_EOI, OP_REOI: begin
                        if (eoi_hit) begin
                            isr_clr = LINES'(1) << eoi_line;
                            base_we = (op == OP_REOI);
                            base_nv = eoi_line + LW'(1);
                        end
                    end
                    OP_SEOI: isr_clr = LINES'(1) << fld;
                    OP_SETPRI: begin
                        base_we = 1'b1;
                        base_nv = fld + LW'(1);
                    end
                    OP_RSEOI: begin
                        isr_clr = LINES'(1) << fld;
                        base_we = 1'b1;
                        base_nv = fld + LW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_ctl_regif.sv
module irq_ctl_regif
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [LINES-1:0] req_vec,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_line,
    input  logic             ack,
    output logic             take_o,
    output logic [LW-1:0]    take_line_o,
    output logic [LINES-1:0] mask_o,
    output logic [LINES-1:0] isr_o,
    output logic [LW-1:0]    base_o,
    output logic [DW-1:0]    vec_base_o,
    output logic             spec_mask_o,
    output logic             sfnm_o
);

    regs_t r_q, r_d;

    // State exposed to the bound checker.
    seq_e seq_q;
    logic poll_q;
    logic aeoi_q;

    logic             init_wr, wr1, poll_rd, take;
    seq_e             seq_nx;
    logic             ld_mask, ld_vbase, ld_w4;
    logic [LINES-1:0] isr_clr, isr_set;
    logic             base_we, rae_we, rae_nv, poll_set;
    logic             rsel_we, rsel_nv, smask_we, smask_nv;
    logic [LW-1:0]    base_nv;

    assign init_wr = wr_en && !addr && wdata[INIT_BIT];
    assign wr1     = wr_en && addr;
    assign poll_rd = rd_en && r_q.poll;
    assign take    = win_valid && (ack || poll_rd);

    irq_ctl_initseq u_seq (
        .seq_q    (r_q.seq),
        .wr1      (wr1),
        .single_q (r_q.single),
        .want4_q  (r_q.want4),
        .seq_nx   (seq_nx),
        .ld_mask  (ld_mask),
        .ld_vbase (ld_vbase),
        .ld_w4    (ld_w4)
    );

    irq_ctl_cmddec u_cmd (
        .cmd_wr   (wr_en && !addr),
        .wdata    (wdata),
        .isr      (r_q.isr),
        .base     (r_q.base),
        .isr_clr  (isr_clr),
        .base_we  (base_we),
        .base_nv  (base_nv),
        .rae_we   (rae_we),
        .rae_nv   (rae_nv),
        .poll_set (poll_set),
        .rsel_we  (rsel_we),
        .rsel_nv  (rsel_nv),
        .smask_we (smask_we),
        .smask_nv (smask_nv)
    );

    always_comb begin
        r_d     = r_q;
        isr_set = '0;

        // Take of the resolver's winner.
        if (take) begin
            if (r_q.aeoi) begin
                if (r_q.rae) r_d.base = win_line + LW'(1);
            end else begin
                isr_set = LINES'(1) << win_line;
            end
        end
        if (poll_rd) r_d.poll = 1'b0;

        // Command effects; clears use the pre-cycle vector, sets land on top.
        r_d.isr = (r_q.isr & ~isr_clr) | isr_set;
        if (base_we)  r_d.base  = base_nv;
        if (rae_we)   r_d.rae   = rae_nv;
        if (poll_set) r_d.poll  = 1'b1;
        if (rsel_we)  r_d.rsel  = rsel_nv;
        if (smask_we) r_d.smask = smask_nv;

        // Address 1 writes steered by the sequencer.
        r_d.seq = seq_nx;
        if (ld_mask)  r_d.mask  = wdata[LINES-1:0];
        if (ld_vbase) r_d.vbase = wdata & VBASE_KEEP;
        if (ld_w4) begin
            r_d.sfnm = wdata[W4_SFNM];
            r_d.aeoi = wdata[W4_AEOI];
        end

        // Start of setup overrides everything else in the cycle.
        if (init_wr) begin
            r_d        = '0;
            r_d.seq    = SEQ_W2;
            r_d.want4  = wdata[W1_FOURTH];
            r_d.single = wdata[W1_SINGLE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (r_q.poll)  rdata = win_valid ? (POLL_FLAG | DW'(win_line)) : '0;
            else if (addr) rdata = DW'(r_q.mask);
            else           rdata = r_q.rsel ? DW'(r_q.isr) : DW'(req_vec);
        end
    end

    assign take_o      = take;
    assign take_line_o = win_line;
    assign mask_o      = r_q.mask;
    assign isr_o       = r_q.isr;
    assign base_o      = r_q.base;
    assign vec_base_o  = r_q.vbase;
    assign spec_mask_o = r_q.smask;
    assign sfnm_o      = r_q.sfnm;
    assign seq_q       = r_q.seq;
    assign poll_q      = r_q.poll;
    assign aeoi_q      = r_q.aeoi;

endmodule

// File: rtl/irq_ctl_regif_chk.sv
module irq_ctl_regif_chk
    import irq_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             addr,
    input logic [DW-1:0]    wdata,
    input logic [DW-1:0]    rdata,
    input logic             win_valid,
    input logic [LW-1:0]    win_line,
    input logic             ack,
    input logic             take_o,
    input logic [LINES-1:0] mask_o,
    input logic [LINES-1:0] isr_o,
    input logic [LW-1:0]    base_o,
    input logic [DW-1:0]    vec_base_o,
    input irq_ctl_pkg::seq_e seq_q,
    input logic             poll_q,
    input logic             aeoi_q
);

    // R2
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[INIT_BIT]) |=> (isr_o == '0 && mask_o == '0 && base_o == '0));

    // R3
    vbase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_q == SEQ_W2) |=> (vec_base_o == ($past(wdata) & VBASE_KEEP)));

    // R6
    idle_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_q == SEQ_IDLE) |=> (mask_o == $past(wdata[LINES-1:0])));

    // R11
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && win_valid && !aeoi_q && !wr_en) |=> isr_o[$past(win_line)]);

    // R12
    poll_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_q && win_valid) |-> (rdata == (POLL_FLAG | DW'(win_line)) && take_o));

    // R12
    poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_q && !wr_en) |=> !poll_q);

    // R13
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !poll_q && addr) |-> (rdata == DW'(mask_o)));

endmodule

bind irq_ctl_regif irq_ctl_regif_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .win_valid  (win_valid),
    .win_line   (win_line),
    .ack        (ack),
    .take_o     (take_o),
    .mask_o     (mask_o),
    .isr_o      (isr_o),
    .base_o     (base_o),
    .vec_base_o (vec_base_o),
    .seq_q      (seq_q),
    .poll_q     (poll_q),
    .aeoi_q     (aeoi_q)
);

// File: tb/irq_ctl_regif_tb_top.sv
module irq_ctl_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0, win_valid = 1'b0;
    logic [7:0] wdata = '0, req_vec = '0;
    logic [2:0] win_line = '0;
    logic [7:0] rdata, mask_o, isr_o, vec_base_o;
    logic [2:0] base_o, take_line_o;
    logic       take_o, spec_mask_o, sfnm_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Behavioural model state.
    int m_mask, m_isr, m_base, m_vb, m_seq, m_aeoi, m_rae, m_smask;
    int m_sfnm, m_poll, m_rsel, m_f4, m_sgl;

    // Stimulus defaults for the resolver side.
    bit       g_wv  = 0;
    bit [2:0] g_wl  = 0;
    bit [7:0] g_req = 8'h00;

    always #5 clk = ~clk;

    irq_ctl_regif dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .req_vec     (req_vec),
        .win_valid   (win_valid),
        .win_line    (win_line),
        .ack         (ack),
        .take_o      (take_o),
        .take_line_o (take_line_o),
        .mask_o      (mask_o),
        .isr_o       (isr_o),
        .base_o      (base_o),
        .vec_base_o  (vec_base_o),
        .spec_mask_o (spec_mask_o),
        .sfnm_o      (sfnm_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = 0; m_isr = 0; m_base = 0; m_vb = 0; m_seq = 0; m_aeoi = 0; m_rae = 0;
        m_smask = 0; m_sfnm = 0; m_poll = 0; m_rsel = 0; m_f4 = 0; m_sgl = 0;
    endtask

    // First in-service line counted from the base upward, -1 if none.
    function automatic int top_isr();
        for (int k = 0; k < 8; k++) begin
            int idx = (m_base + k) % 8;
            if (m_isr[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic model_clock(input bit wr, input bit rd, input bit a, input bit [7:0] wd,
                               input bit ak, input bit wv, input bit [2:0] wl);
        int n_isr = m_isr, n_base = m_base, n_poll = m_poll, n_seq = m_seq;
        int clr = 0, set = 0, hi;
        bit tk = wv && (ak || (rd && m_poll != 0));
        if (tk) begin
            if (m_aeoi != 0) begin
                if (m_rae != 0) n_base = (wl + 1) % 8;
            end else set = 1 << wl;
        end
        if (rd && m_poll != 0) n_poll = 0;
        if (wr && !a && !wd[4]) begin
            if (wd[3]) begin
                if (wd[2]) n_poll = 1;
                if (wd[1]) m_rsel = wd[0];
                if (wd[6]) m_smask = wd[5];
            end else begin
                case (wd[7:5])
                    0: m_rae = 0;
                    4: m_rae = 1;
                    1, 5: begin
                        hi = top_isr();
                        if (hi >= 0) begin
                            clr = 1 << hi;
                            if (wd[7:5] == 5) n_base = (hi + 1) % 8;
                        end
                    end
                    3: clr = 1 << wd[2:0];
                    6: n_base = (wd[2:0] + 1) % 8;
                    7: begin clr = 1 << wd[2:0]; n_base = (wd[2:0] + 1) % 8; end
                    default: ;
                endcase
            end
        end
        if (wr && a) begin
            case (m_seq)
                0: m_mask = wd;
                1: begin
                    m_vb = wd & 8'hF8;
                    if (m_sgl != 0) n_seq = (m_f4 != 0) ? 3 : 0;
                    else n_seq = 2;
                end
                2: n_seq = (m_f4 != 0) ? 3 : 0;
                default: begin m_sfnm = wd[4]; m_aeoi = wd[1]; n_seq = 0; end
            endcase
        end
        m_isr = ((m_isr & ~clr) | set) & 8'hFF;
        m_base = n_base; m_poll = n_poll; m_seq = n_seq;
        if (wr && !a && wd[4]) begin
            model_reset();
            m_seq = 1; m_f4 = wd[0]; m_sgl = wd[1];
        end
    endtask

    task automatic cmp_regs(input string tag);
        chk(tag, "mask", mask_o, m_mask);
        chk(tag, "isr", isr_o, m_isr);
        chk(tag, "base", base_o, m_base);
        chk(tag, "vbase", vec_base_o, m_vb);
        chk(tag, "smask", spec_mask_o, m_smask);
        chk(tag, "sfnm", sfnm_o, m_sfnm);
    endtask

    // One clock: drive at negedge, check combinational outputs, advance model, check registers.
    task automatic step(input bit wr, input bit rd, input bit a, input bit [7:0] wd,
                        input bit ak, input string tag);
        int exp_rd;
        bit tk;
        wr_en = wr; rd_en = rd; addr = a; wdata = wd; ack = ak;
        win_valid = g_wv; win_line = g_wl; req_vec = g_req;
        #1;
        tk = g_wv && (ak || (rd && m_poll != 0));
        if (!rd) exp_rd = 0;
        else if (m_poll != 0) exp_rd = g_wv ? (8'h80 | g_wl) : 0;
        else if (a) exp_rd = m_mask;
        else exp_rd = (m_rsel != 0) ? m_isr : g_req;
        chk(tag, "rdata", rdata, exp_rd);
        chk(tag, "take", take_o, tk);
        if (tk) chk(tag, "take_line", take_line_o, g_wl);
        @(posedge clk);
        model_clock(wr, rd, a, wd, ak, g_wv, g_wl);
        @(negedge clk);
        cmp_regs(tag);
    endtask

    task automatic wr(input bit a, input bit [7:0] d, input string tag);
        step(1, 0, a, d, 0, tag);
    endtask
    task automatic rd(input bit a, input string tag);
        step(0, 1, a, 8'h00, 0, tag);
    endtask
    task automatic take_line(input bit [2:0] l, input string tag);
        g_wv = 1; g_wl = l;
        step(0, 0, 0, 8'h00, 1, tag);
        g_wv = 0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_regs("R1");
        step(0, 0, 0, 8'h00, 0, "R1");
        wr(1, 8'h3C, "R1");                 // idle after reset: mask load
        // Full setup: not single, fourth word follows
        wr(0, 8'h11, "R2");
        wr(1, 8'h47, "R3");
        wr(1, 8'hFF, "R4");
        wr(1, 8'h00, "R5");
        wr(1, 8'h0F, "R6");
        // Single, no fourth word
        wr(0, 8'h12, "R2");
        wr(1, 8'h88, "R3");
        wr(1, 8'h55, "R6");
        // Single with fourth word
        wr(0, 8'h13, "R2");
        wr(1, 8'h20, "R3");
        wr(1, 8'h12, "R5");
        wr(1, 8'h00, "R6");
        // Not single, no fourth word: third word then idle
        wr(0, 8'h10, "R2");
        wr(1, 8'h08, "R3");
        wr(1, 8'h77, "R4");
        wr(1, 8'hA5, "R6");
        // Takes without auto-EOI
        take_line(3, "R11");
        take_line(5, "R11");
        take_line(0, "R11");
        g_req = 8'h5A;
        rd(0, "R13");
        wr(0, 8'h0B, "R7");
        rd(0, "R13");
        rd(1, "R13");
        // End-of-interrupt family
        wr(0, 8'h20, "R9");
        wr(0, 8'hA0, "R9");
        take_line(1, "R11");
        wr(0, 8'h20, "R9");
        wr(0, 8'h61, "R10");
        wr(0, 8'hC2, "R10");
        take_line(6, "R11");
        wr(0, 8'hE6, "R10");
        wr(0, 8'h40, "R10");
        wr(0, 8'h20, "R9");                 // nothing in service
        // Auto-EOI with rotation
        wr(0, 8'h13, "R2");
        wr(1, 8'h00, "R3");
        wr(1, 8'h02, "R5");
        wr(0, 8'h80, "R8");
        take_line(4, "R11");
        wr(0, 8'h00, "R8");
        take_line(2, "R8");
        // Special mask
        wr(0, 8'h68, "R7");
        wr(0, 8'h28, "R7");
        wr(0, 8'h48, "R7");
        // Poll
        wr(0, 8'h0C, "R7");
        g_wv = 1; g_wl = 6;
        rd(0, "R12");
        g_wv = 0;
        rd(0, "R12");
        wr(0, 8'h0C, "R7");
        rd(0, "R12");
        rd(1, "R12");
        // Same-cycle interactions
        wr(0, 8'h10, "R2");
        wr(1, 8'h00, "R3");
        wr(1, 8'h00, "R4");
        take_line(2, "R11");
        g_wv = 1; g_wl = 7;
        step(1, 0, 0, 8'h20, 1, "R14");     // take 7 with non-specific EOI
        g_wv = 0;
        wr(0, 8'h0C, "R14");
        step(1, 1, 0, 8'h0C, 0, "R14");     // poll read while re-arming
        g_wv = 1; g_wl = 1;
        rd(0, "R14");
        g_wv = 0;
        wr(0, 8'h13, "R2");
        wr(1, 8'h00, "R3");
        wr(1, 8'h02, "R5");
        wr(0, 8'h80, "R8");
        g_wv = 1; g_wl = 3;
        step(1, 0, 0, 8'hC5, 1, "R14");     // command base beats take rotation
        g_wv = 0;
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit       w  = ($urandom % 3) == 0;
            bit       r  = ($urandom % 4) == 0;
            bit       a  = $urandom % 2;
            bit [7:0] d  = 8'($urandom);
            bit       ak = ($urandom % 5) == 0;
            if (!a && d[4] && ($urandom % 10) != 0) d[4] = 1'b0;
            g_wv  = $urandom % 2;
            g_wl  = 3'($urandom);
            g_req = 8'($urandom);
            step(w, r, a, d, ak, "R14");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule